// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It does this by reading up to three page table entries, one after another, through a single-word memory read port. A client offers a translation with a valid/ready handshake, together with the byte address of the top table. The walker reads the top entry, then the middle-level entry that entry points to, then the leaf entry. It then reports the physical address, or a fault that names the level where the walk stopped.

The top table has four entries, selected by the two most significant virtual address bits. The middle and leaf tables each have 512 four-byte entries, which makes each one a 2 KB chunk, half of a 4 KB page. An upper-level entry therefore carries a 25-bit chunk pointer. A leaf entry carries a 24-bit frame number. The low 12 bits of the virtual address pass through unchanged as the page offset.

The controller has four states:
- `ST_IDLE`: ready for a request. It moves to `ST_ISSUE` when a request is accepted.
- `ST_ISSUE`: drives the memory read. It moves to `ST_WAIT` when the read is accepted.
- `ST_WAIT`: waits for read data. When the data arrives, it returns to `ST_ISSUE` for the next level, or moves to `ST_DONE` after a leaf entry or an invalid entry.
- `ST_DONE`: presents the result for one cycle, then returns to `ST_IDLE`.

A level register (1, 2 or 3) selects how the entry address is formed.

Top module: `ptw3_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle after the result pulse, so only one translation is in flight at a time.
- R3: The first read goes to `root_base + 4*VA[31:30]`. `root_base` and the VA are captured only when a request is taken; later changes do not affect the walk in progress.
- R4: The second read address is `{E1[24:0], VA[29:21], 2'b00}`, where E1 is the first entry returned.
- R5: The third read address is `{E2[24:0], VA[20:12], 2'b00}`, where E2 is the second entry returned.
- R6: A memory read holds its valid and address steady until `mem_req_ready` is seen. Only one read is outstanding at a time. Stalls and any response latency only delay the result.
- R7: On success, `rsp_valid` is high for exactly one cycle, with `rsp_fault`=0, `rsp_level`=0 and `rsp_pa` = `{E3[23:0], VA[11:0]}`.
- R8: An entry whose bit 31 is 0 ends the walk with no further reads. The result then has `rsp_fault`=1, `rsp_level` = the failing level (1, 2 or 3) and `rsp_pa`=0.
- R9: Entry bits 30:25 (upper levels) and 30:24 (leaf) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| root_base | input | 36 | Byte address of the four-entry top table, 16-byte aligned |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_pa | output | 36 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk stopped at an invalid entry |
| rsp_level | output | 2 | Failing level 1..3, or 0 on success |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |

## Verification
A new request and the previous walk's result can meet in the same cycle. So can a change of the table base and the first entry read of the walk in flight. The bench holds `req_valid` high with a second address and a different `root_base` straight after the first request is taken. It then checks three things. The first result uses the old base. `req_ready` is still low while the result strobe is high. The waiting request is taken only in the following cycle, and its first read uses the new base.

// File: rtl/ptw3_pkg.sv
package ptw3_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 36;
    localparam int OFF_W    = 12;
    localparam int TOP_IX_W = 2;
    localparam int IX_W     = 9;
    localparam int PTE_W    = 32;
    localparam int ENT_SH   = 2;
    localparam int PTR_W    = PA_W - IX_W - ENT_SH;
    localparam int FRM_W    = PA_W - OFF_W;
    localparam int VLD_BIT  = PTE_W - 1;
    localparam int MID_LSB  = OFF_W + IX_W;
    localparam int TOP_LSB  = VA_W - TOP_IX_W;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} walk_st_t;
    typedef enum logic [1:0] {LV_NONE = 2'd0, LV_ONE = 2'd1, LV_TWO = 2'd2, LV_THREE = 2'd3} lvl_t;
endpackage

// File: rtl/ptw3_addr_gen.sv
module ptw3_addr_gen
    import ptw3_pkg::*;
(
    input  lvl_t              lvl,
    input  logic [PA_W-1:0]   base,
    input  logic [VA_W-1:0]   va,
    input  logic [PTR_W-1:0]  ptr,
    output logic [PA_W-1:0]   addr
);
    localparam int TOP_PAD = PA_W - TOP_IX_W - ENT_SH;

    always_comb begin
        unique case (lvl)
            LV_ONE:   addr = base + {{TOP_PAD{1'b0}}, va[TOP_LSB +: TOP_IX_W], {ENT_SH{1'b0}}};
            LV_TWO:   addr = {ptr, va[MID_LSB +: IX_W], {ENT_SH{1'b0}}};
            LV_THREE: addr = {ptr, va[OFF_W +: IX_W], {ENT_SH{1'b0}}};
            default:  addr = base;
        endcase
    end
endmodule

// File: rtl/ptw3_entry_dec.sv
module ptw3_entry_dec
    import ptw3_pkg::*;
(
    input  logic [PTE_W-1:0]  pte,
    output logic              vld,
    output logic [PTR_W-1:0]  ptr,
    output logic [FRM_W-1:0]  frame
);
    assign vld   = pte[VLD_BIT];
    assign ptr   = pte[PTR_W-1:0];
    assign frame = pte[FRM_W-1:0];
endmodule

// File: rtl/ptw3_walker.sv
module ptw3_walker
    import ptw3_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_va,
    input  logic [PA_W-1:0]    root_base,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_fault,
    output logic [1:0]         rsp_level,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_data
);
    walk_st_t           state_q, state_d;
    lvl_t               lvl_q;
    logic [VA_W-1:0]    va_q;
    logic [PA_W-1:0]    base_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [PA_W-1:0]    pa_q;
    logic               fault_q;

    logic               ent_vld;
    logic [PTR_W-1:0]   ent_ptr;
    logic [FRM_W-1:0]   ent_frame;
    logic [PA_W-1:0]    ent_addr;

    ptw3_addr_gen u_addr (
        .lvl  (lvl_q),
        .base (base_q),
        .va   (va_q),
        .ptr  (ptr_q),
        .addr (ent_addr)
    );

    ptw3_entry_dec u_dec (
        .pte   (mem_rsp_data),
        .vld   (ent_vld),
        .ptr   (ent_ptr),
        .frame (ent_frame)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_d = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid)
                          state_d = (!ent_vld || lvl_q == LV_THREE) ? ST_DONE : ST_ISSUE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= LV_NONE;
            va_q    <= '0;
            base_q  <= '0;
            ptr_q   <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            lvl_q   <= LV_ONE;
            va_q    <= req_va;
            base_q  <= root_base;
            fault_q <= 1'b0;
        end else if (state_q == ST_WAIT && mem_rsp_valid) begin
            if (!ent_vld) begin
                fault_q <= 1'b1;
            end else if (lvl_q == LV_THREE) begin
                pa_q <= {ent_frame, va_q[OFF_W-1:0]};
            end else begin
                ptr_q <= ent_ptr;
                lvl_q <= lvl_t'(lvl_q + 2'd1);
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = ent_addr;
        rsp_valid     = (state_q == ST_DONE);
        rsp_fault     = fault_q;
        rsp_pa        = fault_q ? '0 : pa_q;
        rsp_level     = fault_q ? lvl_q : 2'd0;
    end

    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_hold_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    assert_result_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_level == 2'd0 && rsp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]);

    assert_fault_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_level != 2'd0 && rsp_pa == '0);
endmodule

// File: tb/ptw3_walker_test.sv
module ptw3_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [35:0] root_base = '0;
    logic        rsp_valid;
    logic [35:0] rsp_pa;
    logic        rsp_fault;
    logic [1:0]  rsp_level;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [35:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int stall = 0;
    int lat = 0;
    bit finished = 0;
    logic [31:0] pmem [logic [35:0]];
    logic [35:0] rd_log [$];

    always #4 clk = ~clk;

    ptw3_walker uut (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [35:0] a;
                repeat (stall) @(negedge clk);
                mem_req_ready = 1'b1;
                a = mem_req_addr;
                @(negedge clk);
                mem_req_ready = 1'b0;
                rd_log.push_back(a);
                repeat (lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pmem.exists(a) ? pmem[a] : 32'h0;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    function automatic logic [35:0] a1(input logic [35:0] b, input logic [31:0] v);
        return b + {32'h0, v[31:30], 2'b00};
    endfunction
    function automatic logic [35:0] a23(input logic [24:0] p, input logic [8:0] ix);
        return {p, ix, 2'b00};
    endfunction

    task automatic build(input logic [35:0] b, input logic [31:0] v, input logic [24:0] p1,
                         input logic [24:0] p2, input logic [23:0] fr,
                         input bit v1, input bit v2, input bit v3, input logic [6:0] junk);
        pmem[a1(b, v)]           = {v1, junk[5:0], p1};
        pmem[a23(p1, v[29:21])]  = {v2, junk[5:0], p2};
        pmem[a23(p2, v[20:12])]  = {v3, junk, fr};
    endtask

    task automatic wait_rsp(input string tag);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rsp_valid) return;
        end
        check(1'b0, {tag, " no result"}, 0, 1);
    endtask

    task automatic walk(input string tag, input logic [35:0] b, input logic [31:0] v,
                        input logic [24:0] p1, input logic [24:0] p2, input logic [23:0] fr,
                        input bit v1, input bit v2, input bit v3, input logic [6:0] junk);
        int nexp;
        bit ok;
        pmem.delete();
        rd_log.delete();
        build(b, v, p1, p2, fr, v1, v2, v3, junk);
        nexp = !v1 ? 1 : (!v2 ? 2 : 3);
        @(negedge clk);
        check(req_ready == 1'b1, {tag, " R2 ready when idle"}, req_ready, 1);
        req_valid = 1'b1; req_va = v; root_base = b;
        @(negedge clk);
        req_valid = 1'b0;
        root_base = ~b & 36'hF_FFFF_FFF0;
        check(req_ready == 1'b0, {tag, " R2 busy"}, req_ready, 0);
        wait_rsp(tag);
        check(rd_log.size() == nexp, {tag, " R8 read count"}, rd_log.size(), nexp);
        if (rd_log.size() > 0) check(rd_log[0] == a1(b, v), {tag, " R3 L1 addr"}, rd_log[0], a1(b, v));
        if (rd_log.size() > 1 && nexp > 1)
            check(rd_log[1] == a23(p1, v[29:21]), {tag, " R4 L2 addr"}, rd_log[1], a23(p1, v[29:21]));
        if (rd_log.size() > 2 && nexp > 2)
            check(rd_log[2] == a23(p2, v[20:12]), {tag, " R5 L3 addr"}, rd_log[2], a23(p2, v[20:12]));
        if (nexp == 3 && v3) begin
            ok = !rsp_fault && rsp_level == 0 && rsp_pa == {fr, v[11:0]};
            check(ok, {tag, " R7 R9 result"}, {rsp_fault, rsp_level, rsp_pa}, {3'b000, fr, v[11:0]});
        end else begin
            ok = rsp_fault && rsp_level == 2'(nexp) && rsp_pa == '0;
            check(ok, {tag, " R8 fault"}, {rsp_fault, rsp_level, rsp_pa}, {1'b1, 2'(nexp), 36'h0});
        end
        @(negedge clk);
        check(rsp_valid == 1'b0, {tag, " R7 pulse width"}, rsp_valid, 0);
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1 && mem_req_valid == 1'b0 && rsp_valid == 1'b0, "R1 reset state",
              {req_ready, mem_req_valid, rsp_valid}, 3'b100);
    endtask

    task automatic t_plain();
        stall = 0; lat = 0;
        walk("plain", 36'h0_8000_0040, 32'hC2A5_7ABC, 25'h1ABCDE5, 25'h0F0F0F1, 24'hFEDCBA, 1, 1, 1, 7'h00);
    endtask

    task automatic t_slow_junk();
        stall = 3; lat = 5;
        walk("slow R6 R9", 36'hF_FFFF_FFF0, 32'h4013_F00F, 25'h1FFFFFF, 25'h0000001, 24'h000123, 1, 1, 1, 7'h7F);
    endtask

    task automatic t_faults();
        stall = 1; lat = 2;
        walk("fault L1", 36'h0_0000_1230, 32'h0000_0001, 25'h0000100, 25'h0000200, 24'h000300, 0, 1, 1, 7'h15);
        walk("fault L2", 36'h0_0000_1230, 32'h8765_4321, 25'h0000100, 25'h0000200, 24'h000300, 1, 0, 1, 7'h2A);
        walk("fault L3", 36'h0_0000_1230, 32'hFFFF_FFFF, 25'h0000100, 25'h0000200, 24'h000300, 1, 1, 0, 7'h00);
    endtask

    task automatic t_overlap();
        logic [35:0] b1 = 36'h1_0000_0000, b2 = 36'h2_0000_0010;
        logic [31:0] va = 32'h8020_1555, vb = 32'h4030_2AAA;
        stall = 0; lat = 1;
        pmem.delete(); rd_log.delete();
        build(b1, va, 25'h0000A00, 25'h0000B00, 24'h0ACE01, 1, 1, 1, 7'h00);
        build(b2, vb, 25'h0000C00, 25'h0000D00, 24'h0BEE02, 1, 1, 1, 7'h00);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; root_base = b1;
        @(negedge clk);
        req_va = vb; root_base = b2;
        wait_rsp("overlap A");
        check(rsp_pa == {24'h0ACE01, va[11:0]}, "overlap R3 old base used", rsp_pa, {24'h0ACE01, va[11:0]});
        check(req_ready == 1'b0, "overlap R2 not ready during result", req_ready, 0);
        @(negedge clk);
        check(req_ready == 1'b1, "overlap R2 ready after result", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp("overlap B");
        check(rsp_pa == {24'h0BEE02, vb[11:0]}, "overlap R7 second result", rsp_pa, {24'h0BEE02, vb[11:0]});
        check(rd_log.size() == 6, "overlap R6 read count", rd_log.size(), 6);
        if (rd_log.size() == 6) begin
            check(rd_log[0] == a1(b1, va), "overlap R3 A first read", rd_log[0], a1(b1, va));
            check(rd_log[3] == a1(b2, vb), "overlap R3 B first read", rd_log[3], a1(b2, vb));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_slow_junk();
        t_faults();
        t_overlap();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule